// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Controller

This block is the processor-facing half of a two-level interrupt controller. It sits between a shared source layer and one CPU. It holds one offered interrupt at a time, the CPU's current priority and a separate priority register for inter-processor interrupts (IPIs). It drives a single interrupt line to the CPU. Priorities run on an inverted scale: a lower number is more favoured, and 0xff means that nothing may be presented.

The source layer offers interrupts with a source number and a priority. The CPU side changes the current priority, programs the IPI priority, accepts the pending interrupt and signals end of interrupt. Nothing is queued locally. An offer that loses, or a pending source that is displaced, goes back to the source layer as a reject pulse. When the block becomes able to take more work, it sends a resend pulse so that the source layer offers its held interrupts again.

Top module: `ipc_present`

## Requirements
- R1: After reset the CPU line is low and no pulse is emitted. The current priority, the pending source and the pending priority are zero, and the IPI priority is 0xff. A first accept therefore returns 0x00000000. Raising the current priority to 0xff with nothing pending produces only a resend pulse and no IPI.
- R2: The accepted word holds the current priority in bits 31:24 and the pending source number in bits 23:0. A source field of zero means that nothing is pending.
- R3: An offer is rejected, with its own source number on the reject output, in two cases: its priority is equal to or above the current priority, or a source is already pending with a pending priority equal to or below the offer's priority. The pending state is left unchanged.
- R4: Any other offer first rejects the source that was pending, if there is one. It then latches the offered source and priority and raises the CPU line.
- R5: Accept returns the whole word before the update, lowers the CPU line, clears the source field and loads the current priority from the pending priority.
- R6: End of interrupt loads the current priority from bits 31:24 of the written word and forwards bits 23:0 as an EOI pulse. If nothing is pending, it also runs a resend.
- R7: Writing a current priority below the old one clears the pending source, lowers the line and rejects that source, but only when a source is pending and the new value is equal to or below the pending priority. Otherwise the pending state is kept.
- R8: Writing a current priority equal to or above the old one while nothing is pending runs a resend.
- R9: Writing the IPI priority stores it. If the value is below the current priority, the IPI check runs. The check leaves the state alone when a pending source has a priority equal to or below the IPI priority. Otherwise it rejects any pending source (the IPI source included), latches source number IPI_SRC (default 2) with the IPI priority, and raises the line.
- R10: A resend runs the IPI check first whenever the IPI priority is below the (updated) current priority. It then emits a resend pulse.
- R11: Only one command acts per cycle, in the order accept, end of interrupt, current-priority write, IPI write, offer. Commands of lower rank in the same cycle have no effect.
- R12: Reject, resend, EOI and accept outputs are single-cycle pulses in the cycle after the command. A cycle without a command produces none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_vld | input | 1 | Offer strobe from the source layer |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| cur_wr | input | 1 | Current-priority write strobe |
| cur_prio | input | 8 | New current priority |
| ipi_wr | input | 1 | IPI-priority write strobe |
| ipi_prio | input | 8 | New IPI priority |
| acc_req | input | 1 | Accept strobe |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_word | input | 32 | Priority to restore (31:24) and source to finish (23:0) |
| acc_vld | output | 1 | Accepted word valid pulse |
| acc_word | output | 32 | Accepted word |
| rej_vld | output | 1 | Reject pulse to the source layer |
| rej_src | output | 24 | Rejected source number |
| rsnd_vld | output | 1 | Resend request pulse to the source layer |
| eoi_out_vld | output | 1 | EOI pulse to the source layer |
| eoi_out_src | output | 24 | Source number being finished |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
Several properties are checked on every cycle. The CPU line always matches a non-zero pending source. Offers that lose on current priority are always rejected. Accept and EOI always update the word and the pulses as required, an IPI write on an empty controller always presents the IPI, and an idle cycle never pulses. Other behaviour depends on a sequence of state and is shown only by the bench scenarios. This includes displacement chains, where an offer pushes out an IPI or an IPI pushes out itself, and the boundary cases at equal priorities. It also includes a resend that presents a waiting IPI, and a lower-ranked command in the same cycle being ignored.

// File: rtl/ipc_present.sv
module ipc_present #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     offer_vld,
  input  logic [SRC_W-1:0]         offer_src,
  input  logic [PRIO_W-1:0]        offer_prio,
  input  logic                     cur_wr,
  input  logic [PRIO_W-1:0]        cur_prio,
  input  logic                     ipi_wr,
  input  logic [PRIO_W-1:0]        ipi_prio,
  input  logic                     acc_req,
  input  logic                     eoi_req,
  input  logic [SRC_W+PRIO_W-1:0]  eoi_word,
  output logic                     acc_vld,
  output logic [SRC_W+PRIO_W-1:0]  acc_word,
  output logic                     rej_vld,
  output logic [SRC_W-1:0]         rej_src,
  output logic                     rsnd_vld,
  output logic                     eoi_out_vld,
  output logic [SRC_W-1:0]         eoi_out_src,
  output logic                     cpu_irq
);
  localparam int WORD_W = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] PRIO_OFF = '1;
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] cur_q, pp_q, ipi_q;
  logic [SRC_W-1:0]  src_q;
  logic              irq_q;

  logic [PRIO_W-1:0] n_cur, n_pp, n_ipi;
  logic [SRC_W-1:0]  n_src, n_rsrc, n_esrc;
  logic [WORD_W-1:0] n_aw;
  logic              n_irq, n_rej, n_rsnd, n_eoi, n_ack, chk;

  wire busy = (src_q != '0);

  always_comb begin
    n_cur  = cur_q;
    n_src  = src_q;
    n_pp   = pp_q;
    n_ipi  = ipi_q;
    n_irq  = irq_q;
    n_rej  = 1'b0;
    n_rsrc = '0;
    n_rsnd = 1'b0;
    n_eoi  = 1'b0;
    n_esrc = '0;
    n_ack  = 1'b0;
    n_aw   = acc_word;
    chk    = 1'b0;

    if (acc_req) begin
      n_ack = 1'b1;
      n_aw  = {cur_q, src_q};
      n_src = '0;
      n_cur = pp_q;
      n_irq = 1'b0;
    end else if (eoi_req) begin
      n_cur  = eoi_word[WORD_W-1:SRC_W];
      n_eoi  = 1'b1;
      n_esrc = eoi_word[SRC_W-1:0];
      if (!busy) begin
        n_rsnd = 1'b1;
        chk    = 1'b1;
      end
    end else if (cur_wr) begin
      n_cur = cur_prio;
      if (cur_prio < cur_q) begin
        if (busy && cur_prio <= pp_q) begin
          n_src  = '0;
          n_irq  = 1'b0;
          n_rej  = 1'b1;
          n_rsrc = src_q;
        end
      end else if (!busy) begin
        n_rsnd = 1'b1;
        chk    = 1'b1;
      end
    end else if (ipi_wr) begin
      n_ipi = ipi_prio;
      chk   = 1'b1;
    end else if (offer_vld) begin
      if (offer_prio >= cur_q || (busy && pp_q <= offer_prio)) begin
        n_rej  = 1'b1;
        n_rsrc = offer_src;
      end else begin
        if (busy) begin
          n_rej  = 1'b1;
          n_rsrc = src_q;
        end
        n_src = offer_src;
        n_pp  = offer_prio;
        n_irq = 1'b1;
      end
    end

    if (chk && n_ipi < n_cur && !(n_src != '0 && n_pp <= n_ipi)) begin
      if (n_src != '0) begin
        n_rej  = 1'b1;
        n_rsrc = n_src;
      end
      n_src = IPI_NUM;
      n_pp  = n_ipi;
      n_irq = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q       <= '0;
      src_q       <= '0;
      pp_q        <= '0;
      ipi_q       <= PRIO_OFF;
      irq_q       <= 1'b0;
      rej_vld     <= 1'b0;
      rej_src     <= '0;
      rsnd_vld    <= 1'b0;
      eoi_out_vld <= 1'b0;
      eoi_out_src <= '0;
      acc_vld     <= 1'b0;
      acc_word    <= '0;
    end else begin
      cur_q       <= n_cur;
      src_q       <= n_src;
      pp_q        <= n_pp;
      ipi_q       <= n_ipi;
      irq_q       <= n_irq;
      rej_vld     <= n_rej;
      rej_src     <= n_rsrc;
      rsnd_vld    <= n_rsnd;
      eoi_out_vld <= n_eoi;
      eoi_out_src <= n_esrc;
      acc_vld     <= n_ack;
      acc_word    <= n_aw;
    end
  end

  assign cpu_irq = irq_q;
endmodule

module ipc_present_chk #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    offer_vld,
  input logic [SRC_W-1:0]        offer_src,
  input logic [PRIO_W-1:0]       offer_prio,
  input logic                    cur_wr,
  input logic                    ipi_wr,
  input logic [PRIO_W-1:0]       ipi_prio,
  input logic                    acc_req,
  input logic                    eoi_req,
  input logic [SRC_W+PRIO_W-1:0] eoi_word,
  input logic                    acc_vld,
  input logic [SRC_W+PRIO_W-1:0] acc_word,
  input logic                    rej_vld,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    rsnd_vld,
  input logic                    eoi_out_vld,
  input logic [SRC_W-1:0]        eoi_out_src,
  input logic                    cpu_irq,
  input logic [PRIO_W-1:0]       cur_q,
  input logic [PRIO_W-1:0]       pp_q,
  input logic [SRC_W-1:0]        src_q
);
  localparam int WORD_W = SRC_W + PRIO_W;
  wire any_cmd   = offer_vld | cur_wr | ipi_wr | acc_req | eoi_req;
  wire offer_only = offer_vld & ~(cur_wr | ipi_wr | acc_req | eoi_req);
  wire ipi_only   = ipi_wr & ~(cur_wr | acc_req | eoi_req);

  p_line_tracks_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (src_q != '0));

  p_low_offer_rejected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    offer_only && offer_prio >= cur_q |=> rej_vld && rej_src == $past(offer_src)
      && src_q == $past(src_q));

  p_accept_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> acc_vld && !cpu_irq && acc_word == $past({cur_q, src_q})
      && cur_q == $past(pp_q));

  p_eoi_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_req && !acc_req |=> eoi_out_vld && eoi_out_src == $past(eoi_word[SRC_W-1:0])
      && cur_q == $past(eoi_word[WORD_W-1:SRC_W]));

  p_ipi_presented_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_only && ipi_prio < cur_q && src_q == '0 |=> cpu_irq && src_q == SRC_W'(IPI_SRC));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !any_cmd |=> !rej_vld && !rsnd_vld && !eoi_out_vld && !acc_vld);
endmodule

bind ipc_present ipc_present_chk #(.SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .offer_vld(offer_vld), .offer_src(offer_src),
  .offer_prio(offer_prio), .cur_wr(cur_wr), .ipi_wr(ipi_wr), .ipi_prio(ipi_prio),
  .acc_req(acc_req), .eoi_req(eoi_req), .eoi_word(eoi_word), .acc_vld(acc_vld),
  .acc_word(acc_word), .rej_vld(rej_vld), .rej_src(rej_src), .rsnd_vld(rsnd_vld),
  .eoi_out_vld(eoi_out_vld), .eoi_out_src(eoi_out_src), .cpu_irq(cpu_irq),
  .cur_q(cur_q), .pp_q(pp_q), .src_q(src_q));

// File: tb/ipc_present_tb.sv
module ipc_present_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        offer_vld = 0, cur_wr = 0, ipi_wr = 0, acc_req = 0, eoi_req = 0;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0, cur_prio = '0, ipi_prio = '0;
  logic [31:0] eoi_word = '0;
  logic        acc_vld, rej_vld, rsnd_vld, eoi_out_vld, cpu_irq;
  logic [31:0] acc_word;
  logic [23:0] rej_src, eoi_out_src;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ipc_present u_dut (
    .clk(clk), .rst_n(rst_n), .offer_vld(offer_vld), .offer_src(offer_src),
    .offer_prio(offer_prio), .cur_wr(cur_wr), .cur_prio(cur_prio), .ipi_wr(ipi_wr),
    .ipi_prio(ipi_prio), .acc_req(acc_req), .eoi_req(eoi_req), .eoi_word(eoi_word),
    .acc_vld(acc_vld), .acc_word(acc_word), .rej_vld(rej_vld), .rej_src(rej_src),
    .rsnd_vld(rsnd_vld), .eoi_out_vld(eoi_out_vld), .eoi_out_src(eoi_out_src),
    .cpu_irq(cpu_irq));

  typedef struct packed {
    logic        rej;
    logic [23:0] rsrc;
    logic        rsnd;
    logic        eoi;
    logic [23:0] esrc;
    logic        irq;
    logic        ack;
    logic [31:0] aw;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  localparam int IDLE = 0, OFFER = 1, SETCUR = 2, SETIPI = 3, ACCEPT = 4, EOI = 5, OFFACC = 6;

  task automatic step(input int op, input logic [31:0] d, input logic [7:0] p,
                      input logic e_rej, input logic [23:0] e_rsrc, input logic e_rsnd,
                      input logic e_eoi, input logic [23:0] e_esrc, input logic e_irq,
                      input logic e_ack, input logic [31:0] e_aw, input string tag);
    exp_t e;
    @(negedge clk);
    offer_vld = 0; cur_wr = 0; ipi_wr = 0; acc_req = 0; eoi_req = 0;
    case (op)
      OFFER:  begin offer_vld = 1; offer_src = d[23:0]; offer_prio = p; end
      SETCUR: begin cur_wr = 1; cur_prio = p; end
      SETIPI: begin ipi_wr = 1; ipi_prio = p; end
      ACCEPT: acc_req = 1;
      EOI:    begin eoi_req = 1; eoi_word = d; end
      OFFACC: begin offer_vld = 1; offer_src = d[23:0]; offer_prio = p; acc_req = 1; end
      default: ;
    endcase
    e = '{rej: e_rej, rsrc: e_rsrc, rsnd: e_rsnd, eoi: e_eoi, esrc: e_esrc,
          irq: e_irq, ack: e_ack, aw: e_aw};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    exp_t  e;
    string t;
    logic  bad;
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        bad = (rej_vld !== e.rej) || (e.rej && rej_src !== e.rsrc) ||
              (rsnd_vld !== e.rsnd) || (eoi_out_vld !== e.eoi) ||
              (e.eoi && eoi_out_src !== e.esrc) || (cpu_irq !== e.irq) ||
              (acc_vld !== e.ack) || (e.ack && acc_word !== e.aw);
        checks++;
        if (bad) begin
          failures++;
          $display("FAIL %s: actual rej=%b/%h rsnd=%b eoi=%b/%h irq=%b ack=%b/%h expected rej=%b/%h rsnd=%b eoi=%b/%h irq=%b ack=%b/%h",
                   t, rej_vld, rej_src, rsnd_vld, eoi_out_vld, eoi_out_src, cpu_irq, acc_vld, acc_word,
                   e.rej, e.rsrc, e.rsnd, e.eoi, e.esrc, e.irq, e.ack, e.aw);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(IDLE,   0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 quiet after reset");
    step(ACCEPT, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_0000, "R1 R2 reset word");
    step(OFFER,  32'h40, 8'h05, 1, 24'h40, 0, 0, 0, 0, 0, 0, "R3 offer vs priority 0");
    step(IDLE,   0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 reject lasts one cycle");
    step(SETCUR, 0, 8'hff, 0, 0, 1, 0, 0, 0, 0, 0, "R8 R1 resend, no IPI at 0xff");
    step(OFFER,  32'h40, 8'h10, 0, 0, 0, 0, 0, 1, 0, 0, "R4 latch first offer");
    step(OFFER,  32'h41, 8'h10, 1, 24'h41, 0, 0, 0, 1, 0, 0, "R3 equal pending priority");
    step(OFFER,  32'h42, 8'h08, 1, 24'h40, 0, 0, 0, 1, 0, 0, "R4 displace pending");
    step(OFFER,  32'h43, 8'hff, 1, 24'h43, 0, 0, 0, 1, 0, 0, "R3 offer at 0xff");
    step(ACCEPT, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hff00_0042, "R5 R2 accept word");
    step(OFFER,  32'h44, 8'h08, 1, 24'h44, 0, 0, 0, 0, 0, 0, "R3 equal current priority");
    step(OFFER,  32'h44, 8'h03, 0, 0, 0, 0, 0, 1, 0, 0, "R4 latch below current");
    step(EOI,    32'hff00_0042, 0, 0, 0, 0, 1, 24'h42, 1, 0, 0, "R6 EOI while pending");
    step(ACCEPT, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hff00_0044, "R5 accept after EOI");
    step(EOI,    32'hff00_0044, 0, 0, 0, 1, 1, 24'h44, 0, 0, 0, "R6 EOI with resend");
    step(SETIPI, 0, 8'h20, 0, 0, 0, 0, 0, 1, 0, 0, "R9 IPI presented");
    step(SETIPI, 0, 8'h30, 0, 0, 0, 0, 0, 1, 0, 0, "R9 IPI kept by better pending");
    step(OFFER,  32'h45, 8'h10, 1, 24'h2, 0, 0, 0, 1, 0, 0, "R4 offer displaces IPI");
    step(SETCUR, 0, 8'h10, 1, 24'h45, 0, 0, 0, 0, 0, 0, "R7 pending cleared and rejected");
    step(SETCUR, 0, 8'h40, 0, 0, 1, 0, 0, 1, 0, 0, "R10 resend presents IPI");
    step(SETCUR, 0, 8'h38, 0, 0, 0, 0, 0, 1, 0, 0, "R7 pending kept");
    step(ACCEPT, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h3800_0002, "R5 accept IPI");
    step(SETIPI, 0, 8'h05, 0, 0, 0, 0, 0, 1, 0, 0, "R9 IPI below current");
    step(SETIPI, 0, 8'h01, 1, 24'h2, 0, 0, 0, 1, 0, 0, "R9 IPI displaces itself");
    step(OFFACC, 32'h46, 8'h00, 0, 0, 0, 0, 0, 0, 1, 32'h3000_0002, "R11 accept wins over offer");
    step(IDLE,   0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 idle cycle");
    step(EOI,    32'h0000_0046, 0, 0, 0, 1, 1, 24'h46, 0, 0, 0, "R6 EOI to priority 0");
    step(ACCEPT, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_0000, "R11 ignored offer left nothing");
    step(IDLE,   0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 final idle");
    while (exp_q.size() > 0) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("TIMEOUT watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule